// File: doc/BRIEF.md
# Sequential Stream Miss Prefetcher

This block watches the misses of a data cache and recognises runs of misses that walk through memory one line at a time, upward or downward. Each recognised run is held in a tracker. Whenever a tracked run advances, the block asks the memory side for the next 64-byte line in that run's direction. It needs no software help: it acts only on the misses it observes, and only on misses whose memory-type attribute marks them as write-back cacheable.

Trackers sit in two pools of unequal size. A small pool holds descending runs and a larger pool holds ascending runs and the misses that are still being trained. A new miss first lands in the ascending pool as an unconfirmed tracker. The next miss to the line directly above confirms an ascending run. The next miss to the line directly below moves the run into the descending pool. Requests never leave the 4 KB page of the miss that caused them. Each tracker keeps at most one pending request. The output is a valid/ready port whose request holds steady under backpressure.

Top module: `seq_stream_prefetcher`

## Requirements
- R1: After a synchronous reset, `pf_valid` is 0 and no tracker is live. The first misses after reset behave as on an empty table.
- R2: A miss with `miss_wb` = 0 is ignored. It creates, advances and removes no tracker, and it never leads to a request.
- R3: A write-back miss that matches no tracker allocates an unconfirmed ascending tracker at its line (line = address bits above bit 5). It causes no request.
- R4: A miss to line L+1 in the same 4 KB page as an ascending tracker whose last line is L confirms or advances that tracker and raises a request for line L+2. The miss is sampled at clock edge k, and `pf_valid` with `pf_addr` = (L+2)·64 appears after edge k+1 when the output is free.
- R5: A miss to line L-1 in the same page as an unconfirmed ascending tracker at line L frees that tracker, places a confirmed tracker at line L-1 in the descending pool, and requests line L-2. A later miss to line L-2 advances the descending tracker and requests line L-3.
- R6: A miss more than one line away from every tracker does not extend any of them. A miss to the line a tracker already holds changes nothing and allocates no second tracker.
- R7: A request never falls outside the page of the miss that caused it. An ascending advance at line offset 63 of a page, or a descending step at offset 0, raises no request, and the tracker's older pending request is dropped.
- R8: The ascending pool holds 12 trackers and the descending pool holds 4. When a pool has no free tracker, the least recently updated tracker in that pool is replaced, along with its pending request.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` stays unchanged.
- R10: A tracker holds at most one pending request, and a newer one overwrites an older one not yet sent. When the output frees up, the pending request of the lowest-numbered tracker is sent, with ascending trackers ahead of descending ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss address is presented this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_wb | input | 1 | Memory-type attribute: 1 for write-back cacheable |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Line-aligned byte address of the request |
| pf_ready | input | 1 | The memory side accepts the offered request |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 64-byte lines, 4 KB pages, 12 ascending and 4 descending trackers. With these values both page edges can be reached with small line numbers. Thirteen ascending or five descending streams are enough to force replacement in each pool, so the least-recently-updated choice is observed directly. A stalled `pf_ready` combined with two advances of one stream shows that the older pending request is overwritten. A final randomized phase mixes several walking cursors, non-cacheable misses and random backpressure so that advances, turns, duplicate misses and evictions can coincide.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // what one observed miss does to the tracker table
  typedef enum logic [2:0] {
    ACT_IDLE,    // no usable miss this cycle
    ACT_DUP,     // miss hits a line a tracker already holds
    ACT_UP_ADV,  // ascending tracker steps up one line
    ACT_DN_ADV,  // descending tracker steps down one line
    ACT_TURN,    // unconfirmed tracker moves to the descending pool
    ACT_NEW      // fresh unconfirmed ascending tracker
  } miss_act_e;

endpackage

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter int N  = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  live,
  output logic [IW-1:0] victim
);

  // rank 0 = most recently updated, rank N-1 = least recently updated
  logic [N-1:0][IW-1:0] rank;
  logic [N-1:0]         oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) rank[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)
          rank[i] <= '0;
        else if (rank[i] < rank[touch_idx])
          rank[i] <= rank[i] + IW'(1);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (rank[g] == IW'(N - 1));
  end

  // a free slot (lowest index) wins over eviction of the oldest
  always_comb begin
    victim = '0;
    for (int i = N - 1; i >= 0; i--)
      if (oldest[i]) victim = IW'(i);
    for (int i = N - 1; i >= 0; i--)
      if (!live[i]) victim = IW'(i);
  end

  // R8
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest));

endmodule

// File: rtl/spf_match.sv
module spf_match #(
  parameter int N_UP   = 12,
  parameter int N_DN   = 4,
  parameter int LINE_W = 26,
  parameter int LIP_W  = 6,
  parameter int UIW    = 4,
  parameter int DIW    = 2
) (
  input  logic [N_UP+N_DN-1:0]             live,
  input  logic [N_UP-1:0]                  up_conf,
  input  logic [N_UP+N_DN-1:0][LINE_W-1:0] last,
  input  logic [LINE_W-1:0]                mline,
  output logic                             dup_hit,
  output logic                             up_hit,
  output logic [UIW-1:0]                   up_idx,
  output logic                             dn_hit,
  output logic [DIW-1:0]                   dn_idx,
  output logic                             turn_hit,
  output logic [UIW-1:0]                   turn_idx
);

  localparam int N_ALL = N_UP + N_DN;
  localparam int PG_W  = LINE_W - LIP_W;

  logic [N_ALL-1:0] eq_v, above_v, below_v;
  logic [N_UP-1:0]  up_adv, turn_v;
  logic [N_DN-1:0]  dn_adv;
  logic [PG_W-1:0]  mpage;

  assign mpage = mline[LINE_W-1:LIP_W];

  for (genvar g = 0; g < N_ALL; g++) begin : g_cmp
    logic same_pg;
    assign same_pg    = (last[g][LINE_W-1:LIP_W] == mpage);
    assign eq_v[g]    = live[g] && (mline == last[g]);
    assign above_v[g] = live[g] && same_pg && (mline == last[g] + LINE_W'(1));
    assign below_v[g] = live[g] && same_pg && (mline == last[g] - LINE_W'(1));
  end

  for (genvar g = 0; g < N_UP; g++) begin : g_up
    assign up_adv[g] = above_v[g];
    assign turn_v[g] = below_v[g] && !up_conf[g];
  end

  for (genvar g = 0; g < N_DN; g++) begin : g_dn
    assign dn_adv[g] = below_v[N_UP + g];
  end

  assign dup_hit  = |eq_v;
  assign up_hit   = |up_adv;
  assign dn_hit   = |dn_adv;
  assign turn_hit = |turn_v;

  // lowest index wins in every class
  always_comb begin
    up_idx   = '0;
    turn_idx = '0;
    dn_idx   = '0;
    for (int i = N_UP - 1; i >= 0; i--) begin
      if (up_adv[i]) up_idx   = UIW'(i);
      if (turn_v[i]) turn_idx = UIW'(i);
    end
    for (int i = N_DN - 1; i >= 0; i--)
      if (dn_adv[i]) dn_idx = DIW'(i);
  end

endmodule

// File: rtl/spf_out.sv
module spf_out #(
  parameter int N_ALL  = 16,
  parameter int LINE_W = 26,
  parameter int LINE_B = 6,
  parameter int ADDR_W = 32,
  parameter int AIW    = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_ALL-1:0]             pend,
  input  logic [N_ALL-1:0][LINE_W-1:0] req_line,
  input  logic                         pf_ready,
  output logic                         pf_valid,
  output logic [ADDR_W-1:0]            pf_addr,
  output logic                         take,
  output logic [AIW-1:0]               take_idx
);

  logic slot_free;

  assign slot_free = !pf_valid || pf_ready;
  assign take      = slot_free && (|pend);

  always_comb begin
    take_idx = '0;
    for (int i = N_ALL - 1; i >= 0; i--)
      if (pend[i]) take_idx = AIW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (slot_free) begin
      pf_valid <= |pend;
      if (|pend) pf_addr <= {req_line[take_idx], {LINE_B{1'b0}}};
    end
  end

  // R9
  pf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

endmodule

// File: rtl/seq_stream_prefetcher.sv
module seq_stream_prefetcher #(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 6,
  parameter int PAGE_B = 12,
  parameter int N_UP   = 12,
  parameter int N_DN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_wb,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_ready
);

  import spf_pkg::*;

  localparam int N_ALL  = N_UP + N_DN;
  localparam int LINE_W = ADDR_W - LINE_B;
  localparam int LIP_W  = PAGE_B - LINE_B;
  localparam int UIW    = (N_UP > 1) ? $clog2(N_UP) : 1;
  localparam int DIW    = (N_DN > 1) ? $clog2(N_DN) : 1;
  localparam int AIW    = (N_ALL > 1) ? $clog2(N_ALL) : 1;

  // tracker table: entries [0, N_UP) ascending, [N_UP, N_ALL) descending
  logic [N_ALL-1:0]             t_vld, t_conf, pend;
  logic [N_ALL-1:0][LINE_W-1:0] t_line, req_line;

  logic [LINE_W-1:0] mline;
  logic              unused_low;
  logic              at_top, at_bot, use_miss;

  assign mline      = miss_addr[ADDR_W-1:LINE_B];
  assign unused_low = ^miss_addr[LINE_B-1:0];
  assign at_top     = &mline[LIP_W-1:0];
  assign at_bot     = ~|mline[LIP_W-1:0];
  assign use_miss   = miss_valid && miss_wb;

  logic           dup_hit, up_hit, dn_hit, turn_hit;
  logic [UIW-1:0] up_idx, turn_idx, up_vict;
  logic [DIW-1:0] dn_idx, dn_vict;

  spf_match #(
    .N_UP(N_UP), .N_DN(N_DN), .LINE_W(LINE_W), .LIP_W(LIP_W), .UIW(UIW), .DIW(DIW)
  ) match_i (
    .live(t_vld), .up_conf(t_conf[N_UP-1:0]), .last(t_line), .mline(mline),
    .dup_hit(dup_hit), .up_hit(up_hit), .up_idx(up_idx),
    .dn_hit(dn_hit), .dn_idx(dn_idx), .turn_hit(turn_hit), .turn_idx(turn_idx)
  );

  miss_act_e act;

  always_comb begin
    if (!use_miss)     act = ACT_IDLE;
    else if (dup_hit)  act = ACT_DUP;
    else if (up_hit)   act = ACT_UP_ADV;
    else if (dn_hit)   act = ACT_DN_ADV;
    else if (turn_hit) act = ACT_TURN;
    else               act = ACT_NEW;
  end

  logic           up_touch, dn_touch;
  logic [UIW-1:0] up_touch_idx;
  logic [DIW-1:0] dn_touch_idx;

  assign up_touch     = (act == ACT_UP_ADV) || (act == ACT_NEW);
  assign up_touch_idx = (act == ACT_UP_ADV) ? up_idx : up_vict;
  assign dn_touch     = (act == ACT_DN_ADV) || (act == ACT_TURN);
  assign dn_touch_idx = (act == ACT_DN_ADV) ? dn_idx : dn_vict;

  spf_lru #(.N(N_UP), .IW(UIW)) lru_up_i (
    .clk(clk), .rst(rst), .touch(up_touch), .touch_idx(up_touch_idx),
    .live(t_vld[N_UP-1:0]), .victim(up_vict)
  );

  spf_lru #(.N(N_DN), .IW(DIW)) lru_dn_i (
    .clk(clk), .rst(rst), .touch(dn_touch), .touch_idx(dn_touch_idx),
    .live(t_vld[N_ALL-1:N_UP]), .victim(dn_vict)
  );

  // one write and at most one release per cycle
  logic              wr_en, wr_conf, wr_pend, kill_en;
  logic [AIW-1:0]    wr_idx, kill_idx;
  logic [LINE_W-1:0] wr_req;

  always_comb begin
    wr_en    = 1'b0;
    wr_conf  = 1'b1;
    wr_pend  = 1'b0;
    wr_idx   = '0;
    wr_req   = mline;
    kill_en  = 1'b0;
    kill_idx = AIW'(turn_idx);
    unique case (act)
      ACT_UP_ADV: begin
        wr_en   = 1'b1;
        wr_idx  = AIW'(up_idx);
        wr_pend = !at_top;
        wr_req  = mline + LINE_W'(1);
      end
      ACT_DN_ADV: begin
        wr_en   = 1'b1;
        wr_idx  = AIW'(N_UP) + AIW'(dn_idx);
        wr_pend = !at_bot;
        wr_req  = mline - LINE_W'(1);
      end
      ACT_TURN: begin
        kill_en = 1'b1;
        wr_en   = 1'b1;
        wr_idx  = AIW'(N_UP) + AIW'(dn_vict);
        wr_pend = !at_bot;
        wr_req  = mline - LINE_W'(1);
      end
      ACT_NEW: begin
        wr_en   = 1'b1;
        wr_idx  = AIW'(up_vict);
        wr_conf = 1'b0;
      end
      default: ;
    endcase
  end

  logic           take;
  logic [AIW-1:0] take_idx;

  spf_out #(
    .N_ALL(N_ALL), .LINE_W(LINE_W), .LINE_B(LINE_B), .ADDR_W(ADDR_W), .AIW(AIW)
  ) out_i (
    .clk(clk), .rst(rst), .pend(pend), .req_line(req_line), .pf_ready(pf_ready),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .take(take), .take_idx(take_idx)
  );

  // later assignments win: a fresh request overrides the hand-off clear
  always_ff @(posedge clk) begin
    if (rst) begin
      t_vld    <= '0;
      t_conf   <= '0;
      pend     <= '0;
      t_line   <= '0;
      req_line <= '0;
    end else begin
      if (take) pend[take_idx] <= 1'b0;
      if (kill_en) begin
        t_vld[kill_idx] <= 1'b0;
        pend[kill_idx]  <= 1'b0;
      end
      if (wr_en) begin
        t_vld[wr_idx]    <= 1'b1;
        t_conf[wr_idx]   <= wr_conf;
        t_line[wr_idx]   <= mline;
        pend[wr_idx]     <= wr_pend;
        req_line[wr_idx] <= wr_req;
      end
    end
  end

  // R2
  non_wb_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !miss_wb) |=> ($stable(t_vld) && $stable(t_line)));

  for (genvar g = 0; g < N_ALL; g++) begin : g_chk
    // R7
    pend_same_page_chk: assert property (@(posedge clk) disable iff (rst)
      pend[g] |-> (req_line[g][LINE_W-1:LIP_W] == t_line[g][LINE_W-1:LIP_W]));
  end

  for (genvar g = N_UP; g < N_ALL; g++) begin : g_dchk
    // R5
    dn_confirmed_chk: assert property (@(posedge clk) disable iff (rst)
      t_vld[g] |-> t_conf[g]);
  end

endmodule

// File: tb/seq_stream_prefetcher_tb_top.sv
module seq_stream_prefetcher_tb_top;

  localparam int NU = 12;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_wb = 1'b0;
  logic        pf_ready = 1'b1;
  logic        pf_valid;
  logic [31:0] pf_addr;

  always #10 clk = ~clk;

  seq_stream_prefetcher dut_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_wb(miss_wb), .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  task automatic chk(string req, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit     m_vld[NU+ND], m_conf[NU+ND], m_pend[NU+ND];
  longint m_line[NU+ND], m_req[NU+ND];
  int     up_q[$], dn_q[$];
  bit     m_pfv;
  longint m_pfa;
  longint acc_q[$];

  function automatic void m_reset();
    for (int i = 0; i < NU + ND; i++) begin
      m_vld[i] = 0; m_conf[i] = 0; m_pend[i] = 0; m_line[i] = 0; m_req[i] = 0;
    end
    up_q.delete(); dn_q.delete();
    for (int i = NU - 1; i >= 0; i--) up_q.push_back(i);
    for (int i = ND - 1; i >= 0; i--) dn_q.push_back(i);
    m_pfv = 0; m_pfa = 0;
  endfunction

  function automatic void m_touch(bit dn, int idx);
    if (dn) begin
      foreach (dn_q[k]) if (dn_q[k] == idx) begin dn_q.delete(k); break; end
      dn_q.push_back(idx);
    end else begin
      foreach (up_q[k]) if (up_q[k] == idx) begin up_q.delete(k); break; end
      up_q.push_back(idx);
    end
  endfunction

  function automatic int m_victim(bit dn);
    int base = dn ? NU : 0;
    int n = dn ? ND : NU;
    for (int i = 0; i < n; i++) if (!m_vld[base + i]) return i;
    return dn ? dn_q[0] : up_q[0];
  endfunction

  function automatic void m_step(bit mv, longint a, bit wb, bit rdy);
    int take = -1;
    longint L = a >> 6;
    longint pg = L >> 6;
    int hu = -1, hd = -1, ht = -1;
    bit dup = 0;
    if (!m_pfv || rdy) begin
      for (int i = 0; i < NU + ND; i++) if (m_pend[i] && take < 0) take = i;
      if (take >= 0) begin
        m_pfv = 1; m_pfa = m_req[take] * 64; m_pend[take] = 0;
      end else m_pfv = 0;
    end
    if (!(mv && wb)) return;
    for (int i = 0; i < NU + ND; i++) begin
      if (!m_vld[i]) continue;
      if (m_line[i] == L) dup = 1;
      if ((m_line[i] >> 6) != pg) continue;
      if (i < NU && hu < 0 && m_line[i] + 1 == L) hu = i;
      if (i < NU && ht < 0 && !m_conf[i] && m_line[i] - 1 == L) ht = i;
      if (i >= NU && hd < 0 && m_line[i] - 1 == L) hd = i;
    end
    if (dup) return;
    if (hu >= 0) begin
      m_conf[hu] = 1; m_line[hu] = L; m_pend[hu] = ((L % 64) != 63);
      m_req[hu] = L + 1; m_touch(0, hu);
    end else if (hd >= 0) begin
      m_line[hd] = L; m_pend[hd] = ((L % 64) != 0); m_req[hd] = L - 1;
      m_touch(1, hd - NU);
    end else if (ht >= 0) begin
      int v = m_victim(1);
      m_vld[ht] = 0; m_pend[ht] = 0;
      m_vld[NU + v] = 1; m_conf[NU + v] = 1; m_line[NU + v] = L;
      m_pend[NU + v] = ((L % 64) != 0); m_req[NU + v] = L - 1;
      m_touch(1, v);
    end else begin
      int v = m_victim(0);
      m_vld[v] = 1; m_conf[v] = 0; m_line[v] = L; m_pend[v] = 0;
      m_touch(0, v);
    end
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst && pf_valid && pf_ready) acc_q.push_back(longint'(pf_addr));
    if (rst) m_reset();
    else m_step(miss_valid, longint'(miss_addr), miss_wb, pf_ready);
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " pf_valid"}, pf_valid == m_pfv, pf_valid, m_pfv);
      if (m_pfv) chk({cur_req, " pf_addr"}, longint'(pf_addr) == m_pfa, pf_addr, m_pfa);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic miss(longint line, bit wb = 1'b1, int off = 0);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = 32'(line * 64 + off); miss_wb = wb;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    acc_q.delete();
  endtask

  function automatic bit acc_has(longint a);
    foreach (acc_q[k]) if (acc_q[k] == a) return 1;
    return 0;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    do_reset();
    @(negedge clk);
    cur_req = "R1";
    chk("R1 reset pf_valid", pf_valid == 1'b0, pf_valid, 0);

    // R2: non-cacheable misses leave no trace
    cur_req = "R2";
    miss(100, 0); miss(101, 0); miss(102, 0); miss(103, 1); idle(4);
    chk("R2 no request from ignored misses", acc_q.size() == 0, acc_q.size(), 0);
    miss(104); idle(4);
    chk("R2 stream starts at first cacheable miss", acc_q.size() == 1 && acc_has(105 * 64),
        acc_q.size(), 1);

    // R3 / R4: allocate, confirm, advance
    cur_req = "R3"; acc_q.delete();
    miss(200, 1, 8); idle(4);
    chk("R3 single miss issues nothing", acc_q.size() == 0, acc_q.size(), 0);
    cur_req = "R4";
    miss(201, 1, 40); idle(4);
    chk("R4 confirm requests next line", acc_q.size() == 1 && acc_has(202 * 64),
        acc_q.size() ? acc_q[0] : -1, 202 * 64);
    miss(202); idle(4);
    chk("R4 advance requests next line", acc_q.size() == 2 && acc_has(203 * 64),
        acc_q.size(), 2);

    // R5: descending
    cur_req = "R5"; acc_q.delete();
    miss(300); miss(299); idle(4);
    chk("R5 turn requests line below", acc_q.size() == 1 && acc_has(298 * 64),
        acc_q.size() ? acc_q[0] : -1, 298 * 64);
    miss(298); idle(4);
    chk("R5 descending advance", acc_q.size() == 2 && acc_has(297 * 64), acc_q.size(), 2);

    // R6: gaps and duplicates
    cur_req = "R6"; acc_q.delete();
    miss(500); miss(502); idle(4);
    chk("R6 two-line gap issues nothing", acc_q.size() == 0, acc_q.size(), 0);
    miss(502, 1, 12); miss(503); idle(4);
    chk("R6 duplicate then advance gives one request", acc_q.size() == 1 && acc_has(504 * 64),
        acc_q.size(), 1);

    // R7: page edges (64 lines per page)
    cur_req = "R7"; acc_q.delete();
    miss(20 * 64 + 61); miss(20 * 64 + 62); miss(20 * 64 + 63); idle(4);
    chk("R7 no request past page top", acc_q.size() == 1 && acc_has((20 * 64 + 63) * 64),
        acc_q.size(), 1);
    miss(30 * 64 + 1); miss(30 * 64); idle(4);
    chk("R7 no request below page bottom", acc_q.size() == 1, acc_q.size(), 1);

    // R8: replacement in both pools
    do_reset();
    cur_req = "R8";
    for (int k = 0; k < 13; k++) miss(3000 + 10 * k);
    idle(3); acc_q.delete();
    miss(3021); miss(3001); idle(4);
    chk("R8 oldest ascending tracker replaced", acc_q.size() == 1 && acc_has(3022 * 64),
        acc_q.size(), 1);
    for (int k = 0; k < 5; k++) begin
      miss(4000 + 10 * k); miss(3999 + 10 * k);
    end
    idle(6); acc_q.delete();
    miss(3998); miss(4008); idle(4);
    chk("R8 oldest descending tracker replaced", acc_q.size() == 1 && acc_has(4007 * 64),
        acc_q.size(), 1);

    // R9 / R10: backpressure and overwrite
    cur_req = "R9"; acc_q.delete();
    @(negedge clk); pf_ready = 1'b0;
    miss(6000); miss(6001); idle(5);
    chk("R9 request held valid", pf_valid == 1'b1, pf_valid, 1);
    chk("R9 request address held", pf_addr == 32'(6002 * 64), pf_addr, 6002 * 64);
    cur_req = "R10";
    miss(6002); miss(6003); miss(7000); miss(7001); idle(3);
    chk("R10 stalled output unchanged", pf_addr == 32'(6002 * 64), pf_addr, 6002 * 64);
    pf_ready = 1'b1; idle(6);
    chk("R10 three requests leave", acc_q.size() == 3, acc_q.size(), 3);
    chk("R10 stale request overwritten", !acc_has(6003 * 64) && acc_has(6004 * 64),
        acc_has(6003 * 64), 0);

    // randomized mix of walking cursors, compared against the model
    cur_req = "R10 mixed";
    begin
      longint cur[4] = '{8000, 8100, 8200, 8300};
      for (int n = 0; n < 3000; n++) begin
        @(negedge clk);
        pf_ready = ($urandom % 4) != 0;
        if (($urandom % 2) == 0) begin
          int c = $urandom % 4;
          int r = $urandom % 10;
          if (c < 2) cur[c] += (r < 8) ? 1 : 3;
          else       cur[c] -= (r < 8) ? 1 : 0;
          if (r == 9) cur[c] = 8000 + $urandom_range(0, 400);
          miss_valid = 1'b1;
          miss_addr  = 32'(cur[c] * 64 + ($urandom % 64));
          miss_wb    = ($urandom % 10) != 0;
        end else begin
          miss_valid = 1'b0;
        end
      end
      @(negedge clk); miss_valid = 1'b0; pf_ready = 1'b1;
      idle(20);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule